// File: doc/BRIEF.md
# Double-Buffered Single-Channel PWM Generator

This block produces one pulse-width-modulated output from a free-running up-counter. Software sets a period and a compare value through a small word-addressed register port. Each of the two timing values is held in two places: an active copy that drives the waveform, and a staged copy that software may write at any time. A staged value is moved into the active copy only at the end of the current period, so changing the waveform while it runs never truncates a period. Writes to an active copy take effect at once, which is how software loads timing while the counter is stopped.

A 16-bit control register starts and stops the counter, turns the waveform on (when off, the output is held low), and picks the polarity. With normal polarity the compare value is the number of high cycles per period. With inverted polarity it is the number of low cycles. The counter counts 0, 1, ..., P and then wraps to 0, so a period value P gives a waveform of P+1 clock cycles. A period value of 0 is the shortest waveform, one cycle long. The register port is plain control access with no back-pressure: a write completes in the cycle `reg_wr` is sampled high, and read data is a combinational function of `reg_addr`.

Top module: `shadow_pwm`

## Requirements
- R1: After reset every register reads 0, the counter is stopped at 0 and `pwm_out` is 0.
- R2: Registers are at byte addresses 0x08 (active period), 0x0C (active compare), 0x10 (staged period), 0x14 (staged compare) and 0x2A (control, 16 bits wide, upper read bits 0). Each one reads back the last value written to it. An active register also reads back a value moved into it from its staged copy.
- R3: While control bit 4 (run) is 1, the counter steps by one per clock from 0 up to the active period P and then returns to 0, giving a period of P+1 cycles. While run is 0, the counter holds its value.
- R4: With control bit 10 (polarity) at 0 and active compare C below P, `pwm_out` is high while the counter is below C, which gives C high cycles per period.
- R5: If C is greater than or equal to P, the waveform level is constant: always high with normal polarity and always low with inverted polarity.
- R6: With control bit 10 at 1, the output is the complement of the normal-polarity waveform, so C sets the low time.
- R7: While control bit 9 (waveform enable) is 0, `pwm_out` is 0 whatever the counter, polarity and timing values are.
- R8: A write to a staged register leaves the active copy unchanged until the counter wraps. On the wrap cycle, the most recently written staged value is copied into the active register. A staged copy that has not been written since its last transfer is not copied.
- R9: A write to an active register changes the waveform from the next cycle on, in the middle of a period if needed. If the same cycle is also a transfer cycle, the direct write takes precedence.
- R10: A period value of 0 gives a one-cycle period.
- R11: A write to an address that is not mapped changes no register, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 6 | Byte address for both read and write |
| reg_wdata | input | 32 | Write data. The control register takes bits 15:0 |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | Waveform output |

## Verification
The bench writes staged values in the middle of a period and then counts high cycles on each side of the wrap. A design that loads staged values immediately would cut the running period short. A design that never loads them would keep the old duty, and both give a different count. Boundary timing values are covered: compare equal to the period, compare above the period, compare of zero and a period of zero. A comparator that is off by one shows up there as a count that is one high cycle too many or too few. The bench also stops the counter partway through a period and expects a frozen level. It clears the waveform enable with inverted polarity and expects a low output, which catches a design that inverts after the enable gate. Finally it writes an unmapped address and expects nothing to change, which exposes loose address decoding.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;
  localparam int ADDR_W = 6;
  localparam int CTRL_W = 16;

  // byte addresses decoded by software
  localparam logic [ADDR_W-1:0] A_PER_ACT = 6'h08;
  localparam logic [ADDR_W-1:0] A_CMP_ACT = 6'h0C;
  localparam logic [ADDR_W-1:0] A_PER_STG = 6'h10;
  localparam logic [ADDR_W-1:0] A_CMP_STG = 6'h14;
  localparam logic [ADDR_W-1:0] A_CTRL    = 6'h2A;

  // control bit positions
  localparam int B_RUN  = 4;
  localparam int B_WAVE = 9;
  localparam int B_INV  = 10;

  // index of each double-buffered timing value
  localparam int N_TIMING = 2;
  localparam int IDX_PER  = 0;
  localparam int IDX_CMP  = 1;
endpackage

// File: rtl/pwm_dbuf_reg.sv
module pwm_dbuf_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_act,
  input  logic         wr_stg,
  input  logic [W-1:0] wdata,
  input  logic         wrap,
  output logic [W-1:0] act_val,
  output logic [W-1:0] stg_val,
  output logic         pending
);
  logic [W-1:0] act_q, stg_q;
  logic         pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      stg_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      // transfer at the period boundary, a direct write overrides it
      if (wrap && pend_q) act_q <= stg_q;
      if (wr_act)         act_q <= wdata;
      if (wr_stg) begin
        stg_q  <= wdata;
        pend_q <= 1'b1;
      end else if (wrap) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign act_val = act_q;
  assign stg_val = stg_q;
  assign pending = pend_q;
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import shadow_pwm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  input  logic              wrap,
  output logic [W-1:0]      reg_rdata,
  output logic [W-1:0]      per_act,
  output logic [W-1:0]      cmp_act,
  output logic [CTRL_W-1:0] ctrl,
  output logic [N_TIMING-1:0] pend
);
  logic [W-1:0] act_v [N_TIMING];
  logic [W-1:0] stg_v [N_TIMING];
  logic [CTRL_W-1:0] ctrl_q;

  for (genvar g = 0; g < N_TIMING; g++) begin : g_timing
    localparam logic [ADDR_W-1:0] ADR_ACT = (g == IDX_PER) ? A_PER_ACT : A_CMP_ACT;
    localparam logic [ADDR_W-1:0] ADR_STG = (g == IDX_PER) ? A_PER_STG : A_CMP_STG;
    pwm_dbuf_reg #(.W(W)) u_dbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_act  (reg_wr && reg_addr == ADR_ACT),
      .wr_stg  (reg_wr && reg_addr == ADR_STG),
      .wdata   (reg_wdata),
      .wrap    (wrap),
      .act_val (act_v[g]),
      .stg_val (stg_v[g]),
      .pending (pend[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_PER_ACT: reg_rdata = act_v[IDX_PER];
      A_CMP_ACT: reg_rdata = act_v[IDX_CMP];
      A_PER_STG: reg_rdata = stg_v[IDX_PER];
      A_CMP_STG: reg_rdata = stg_v[IDX_CMP];
      A_CTRL:    reg_rdata[CTRL_W-1:0] = ctrl_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign per_act = act_v[IDX_PER];
  assign cmp_act = act_v[IDX_CMP];
  assign ctrl    = ctrl_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  // ">=" keeps the counter bounded when the period is lowered mid-count
  assign wrap = run && (cnt_q >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen #(
  parameter int W = 32
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] period,
  input  logic [W-1:0] compare,
  input  logic         wave_en,
  input  logic         invert,
  output logic         wave
);
  logic level;

  always_comb begin
    if (compare >= period) level = 1'b1;
    else                   level = (count < compare);
  end

  // the enable gate sits after the polarity so a disabled output is low
  assign wave = wave_en & (level ^ invert);
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
  import shadow_pwm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              pwm_out
);
  logic [W-1:0]        per_act, cmp_act, cnt;
  logic [CTRL_W-1:0]   ctrl;
  logic [N_TIMING-1:0] pend;
  logic                wrap;

  pwm_regfile #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .wrap      (wrap),
    .reg_rdata (reg_rdata),
    .per_act   (per_act),
    .cmp_act   (cmp_act),
    .ctrl      (ctrl),
    .pend      (pend)
  );

  pwm_timebase #(.W(W)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl[B_RUN]),
    .period (per_act),
    .count  (cnt),
    .wrap   (wrap)
  );

  pwm_wavegen #(.W(W)) u_wave (
    .count   (cnt),
    .period  (per_act),
    .compare (cmp_act),
    .wave_en (ctrl[B_WAVE]),
    .invert  (ctrl[B_INV]),
    .wave    (pwm_out)
  );
endmodule

// File: rtl/shadow_pwm_chk.sv
module shadow_pwm_chk
  import shadow_pwm_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic              pwm_out,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      per_act,
  input logic [CTRL_W-1:0] ctrl,
  input logic [N_TIMING-1:0] pend
);
  logic [W-1:0] stg_per_mirror;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_per_mirror <= '0;
    else if (reg_wr && reg_addr == A_PER_STG) stg_per_mirror <= reg_wdata;
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_low_R1: assert (pwm_out == 1'b0);
  end

  assert_disabled_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[B_WAVE] |-> !pwm_out);

  assert_stopped_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[B_RUN] |=> $stable(cnt));

  assert_wraps_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[B_RUN] && cnt >= per_act) |=> cnt == '0);

  assert_steps_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[B_RUN] && cnt < per_act) |=> cnt == $past(cnt) + 1'b1);

  assert_period_kept_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctrl[B_RUN] && cnt >= per_act) && !(reg_wr && reg_addr == A_PER_ACT))
      |=> $stable(per_act));

  assert_period_loaded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[B_RUN] && cnt >= per_act && pend[IDX_PER] && !(reg_wr && reg_addr == A_PER_ACT))
      |=> per_act == $past(stg_per_mirror));

  assert_direct_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_PER_ACT) |=> per_act == $past(reg_wdata));
endmodule

bind shadow_pwm shadow_pwm_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pwm_out   (pwm_out),
  .cnt       (cnt),
  .per_act   (per_act),
  .ctrl      (ctrl),
  .pend      (pend)
);

// File: tb/test_shadow_pwm.sv
module test_shadow_pwm;
  localparam logic [5:0] PA = 6'h08, CA = 6'h0C, PS = 6'h10, CS = 6'h14, CT = 6'h2A;
  localparam logic [31:0] RUN = 32'h10, SYN = 32'hC0, WAV = 32'h200, INV = 32'h400;
  localparam int NV = 8;
  // {period[7:0], compare[7:0], invert, high cycles per period[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {8'd9,  8'd3, 1'b0, 8'd3},   // R4
    {8'd9,  8'd3, 1'b1, 8'd7},   // R6
    {8'd4,  8'd0, 1'b0, 8'd0},   // R4 zero compare
    {8'd4,  8'd4, 1'b0, 8'd5},   // R5 compare equals period
    {8'd4,  8'd7, 1'b1, 8'd0},   // R5 + R6
    {8'd0,  8'd0, 1'b0, 8'd1},   // R10
    {8'd7,  8'd1, 1'b0, 8'd1},   // R4
    {8'd15, 8'd8, 1'b1, 8'd8}    // R6
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, pwm_out;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shadow_pwm i_shadow_pwm (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic count_hi(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic start(input logic [31:0] p, input logic [31:0] c, input logic [31:0] extra);
    do_reset();
    wr(PA, p);
    wr(CA, c);
    wr(CT, WAV | RUN | SYN | extra);
  endtask

  initial begin
    logic [31:0] d;
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 out", {31'b0, pwm_out}, 0);
    rd(PA, d); check("R1 per", d, 0);
    rd(CS, d); check("R1 stg cmp", d, 0);
    rd(CT, d); check("R1 ctrl", d, 0);

    // table of timing vectors: three periods each
    for (int v = 0; v < NV; v++) begin
      logic [7:0] p, c, e;
      logic inv;
      {p, c, inv, e} = VEC[v];
      start({24'b0, p}, {24'b0, c}, inv ? INV : 32'h0);
      count_hi((int'(p) + 1) * 3, h);
      check("R4/R5/R6/R10 highs", h, int'(e) * 3);
    end

    // R2 read back, control is 16 bits wide
    do_reset();
    wr(PA, 32'h1234_5678); wr(CA, 32'h0000_00AB);
    wr(PS, 32'h8765_4321); wr(CS, 32'hCAFE_0001);
    wr(CT, 32'hFFFF_00C0);
    rd(PA, d); check("R2 per act", d, 32'h1234_5678);
    rd(CA, d); check("R2 cmp act", d, 32'h0000_00AB);
    rd(PS, d); check("R2 per stg", d, 32'h8765_4321);
    rd(CS, d); check("R2 cmp stg", d, 32'hCAFE_0001);
    rd(CT, d); check("R2 ctrl", d, 32'h0000_00C0);

    // R11 unmapped address
    wr(6'h20, 32'hDEAD_BEEF);
    rd(6'h20, d); check("R11 read zero", d, 0);
    rd(PA, d); check("R11 per unchanged", d, 32'h1234_5678);
    rd(CT, d); check("R11 ctrl unchanged", d, 32'h0000_00C0);

    // R8 staged write mid-period, P=9 C=3 then P=4 C=2
    start(9, 3, 0);           // now at count 0
    repeat (3) @(negedge clk); // count 3
    wr(PS, 4);
    wr(CS, 2);                // now at count 7
    rd(PA, d); check("R8 active per kept", d, 9);
    rd(CA, d); check("R8 active cmp kept", d, 3);
    count_hi(3, h); check("R8 tail of old period", h, 0);
    count_hi(15, h); check("R8 new timing highs", h, 6);
    rd(PA, d); check("R8 per transferred", d, 4);
    rd(CA, d); check("R8 cmp transferred", d, 2);
    rd(PS, d); check("R8 stg per kept", d, 4);

    // R3 stop freezes the counter at 2 (below compare 3)
    start(9, 3, 0);
    wr(CT, WAV | SYN);
    count_hi(20, h); check("R3 frozen high", h, 20);

    // R9 direct active write mid-period: compare 9 = period gives constant high
    start(9, 3, 0);
    wr(CA, 9);
    rd(CA, d); check("R9 readback", d, 9);
    count_hi(20, h); check("R9 immediate effect", h, 20);

    // R7 waveform disabled with inverted polarity
    start(9, 3, 0);
    wr(CT, RUN | SYN | INV);
    count_hi(20, h); check("R7 held low", h, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule